// File: doc/BRIEF.md
# DDR Dual-Channel ADC Sample Assembler

This block sits directly behind the data pins of a dual-channel 14-bit converter that sends its data on both clock edges. Each channel has its own 7-line bus. Within one conversion, the even-numbered bits travel on the rising edge and the odd-numbered bits follow on the next falling edge. The block samples the pins on both edges. It pairs each rising-edge half with the falling-edge half that comes after it, so that both halves always belong to one conversion. It then interleaves the two halves into a 14-bit word per channel.

Each rebuilt word is left-justified into a 16-bit result with two zero bits below it. The two channel results and a common valid strobe are registered on the rising edge, so downstream logic sees plain single-rate samples, one per channel per clock.

A straight double-edge capture pairs the wrong halves. At any rising edge it holds the odd bits of the previous conversion next to the even bits of the current one. The block avoids this by holding the rising-edge half for one rising-edge cycle before it joins the odd half.

Top module: `adc_ddr_assembler`

## Requirements
- R1: Channel A is carried on `ddr_din[6:0]` and channel B on `ddr_din[13:7]`. Line i of a channel bus carries sample bit 2i when sampled on the rising edge and sample bit 2i+1 when sampled on the falling edge.
- R2: In each 16-bit result, the bit taken from line i on the rising edge sits at position 2+2i, and the bit taken from line i on the falling edge sits at position 3+2i.
- R3: The rising-edge half of each result is always paired with the falling-edge half sampled on the falling edge immediately after it, never with the falling edge before it.
- R4: Bits 1 and 0 of both channel results are always zero.
- R5: A conversion whose rising-edge half is sampled at rising edge k appears on the outputs right after rising edge k+2. Conversions come out in the order they arrived, one per clock.
- R6: After reset is released, `smp_valid` stays low for the first two rising edges and rises with the third. It then stays high for as long as reset stays low.
- R7: `rst` is synchronous and active high. While it is sampled high, both channel results and `smp_valid` are zero. A reset in the middle of a stream restarts the R6 fill sequence.
- R8: The two channels are independent. Data on one channel's lines never changes the other channel's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source-synchronous data clock; both edges sample the data lines |
| rst | input | 1 | Synchronous active-high reset |
| ddr_din | input | 14 | Double-rate data lines; [6:0] channel A, [13:7] channel B |
| smp_a | output | 16 | Channel A result, 14 data bits over two zero bits |
| smp_b | output | 16 | Channel B result, 14 data bits over two zero bits |
| smp_valid | output | 1 | High while both results hold a fully assembled conversion |

## Verification
The bound checker keeps its own record of the data lines on both edges. On every cycle it compares each valid result with the rising half from three edges back and the falling half that followed it, so pairing, bit placement and lane mapping are checked continuously. On every cycle it also checks the zero padding, the fill count behind the valid strobe, and the cleared state after reset. Only the bench's scenarios can show that specific patterns get through: alternating all-ones and all-zeros halves, which expose a half-sample skew; walking ones on each channel with the other channel held quiet; a reset in the middle of a stream; and the absence of stray results once the stream stops.

// File: rtl/adc_asm_pkg.sv
`timescale 1ns/1ps
package adc_asm_pkg;
    localparam int unsigned LANE_W      = 7;
    localparam int unsigned NUM_CH      = 2;
    localparam int unsigned PAD_W       = 2;
    localparam int unsigned BUS_W       = LANE_W * NUM_CH;
    localparam int unsigned SMP_W       = 2 * LANE_W;
    localparam int unsigned OUT_W       = SMP_W + PAD_W;
    localparam int unsigned FILL_STAGES = 2;

    typedef logic [LANE_W-1:0]             half_t;
    typedef logic [NUM_CH-1:0][LANE_W-1:0] halves_t;
    typedef logic [OUT_W-1:0]              word_t;
    typedef logic [NUM_CH-1:0][OUT_W-1:0]  words_t;
    typedef logic [FILL_STAGES-1:0]        fill_t;

    // Even half to even positions, odd half to odd positions.
    function automatic logic [SMP_W-1:0] weave(input half_t ev, input half_t od);
        logic [SMP_W-1:0] s;
        s = '0;
        for (int i = 0; i < int'(LANE_W); i++) begin
            s[2*i]   = ev[i];
            s[2*i+1] = od[i];
        end
        return s;
    endfunction

    // Left-justify a rebuilt sample over zero padding.
    function automatic word_t justify(input logic [SMP_W-1:0] s);
        return {s, {PAD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/adc_ddr_capture.sv
`timescale 1ns/1ps
module adc_ddr_capture
    import adc_asm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] ddr_din,
    output halves_t          rise_now,
    output halves_t          fall_prev
);
    typedef struct packed {
        halves_t fall;
    } neg_st_t;

    typedef struct packed {
        halves_t rise;
        halves_t fall_sdr;
    } pos_st_t;

    neg_st_t neg_d, neg_q;
    pos_st_t pos_d, pos_q;

    always_comb begin
        neg_d          = neg_q;
        pos_d          = pos_q;
        neg_d.fall     = halves_t'(ddr_din);
        pos_d.rise     = halves_t'(ddr_din);
        pos_d.fall_sdr = neg_q.fall;
        if (rst) begin
            neg_d = '0;
            pos_d = '0;
        end
    end

    // Falling-edge half.
    always_ff @(negedge clk) begin
        neg_q <= neg_d;
    end

    // Rising-edge half plus transfer of the last falling half.
    always_ff @(posedge clk) begin
        pos_q <= pos_d;
    end

    assign rise_now  = pos_q.rise;
    assign fall_prev = pos_q.fall_sdr;
endmodule

// File: rtl/adc_even_realign.sv
`timescale 1ns/1ps
module adc_even_realign
    import adc_asm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  halves_t rise_now,
    input  halves_t fall_prev,
    output halves_t even_al,
    output halves_t odd_al,
    output logic    pair_ok
);
    typedef struct packed {
        halves_t hold;
        fill_t   fill;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.hold = rise_now;
        st_d.fill = fill_t'({st_q.fill, 1'b1});
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Held rising half now lines up with the falling half that followed it.
    assign even_al = st_q.hold;
    assign odd_al  = fall_prev;
    assign pair_ok = st_q.fill[FILL_STAGES-1];
endmodule

// File: rtl/adc_sample_pack.sv
`timescale 1ns/1ps
module adc_sample_pack
    import adc_asm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  halves_t even_al,
    input  halves_t odd_al,
    input  logic    pair_ok,
    output words_t  words,
    output logic    words_vld
);
    typedef struct packed {
        words_t w;
        logic   v;
    } st_t;

    st_t    st_d, st_q;
    words_t built;

    for (genvar ch = 0; ch < int'(NUM_CH); ch++) begin : g_ch
        assign built[ch] = justify(weave(even_al[ch], odd_al[ch]));
    end

    always_comb begin
        st_d   = st_q;
        st_d.w = built;
        st_d.v = pair_ok;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign words     = st_q.w;
    assign words_vld = st_q.v;
endmodule

// File: rtl/adc_ddr_assembler.sv
`timescale 1ns/1ps
module adc_ddr_assembler
    import adc_asm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] ddr_din,
    output logic [OUT_W-1:0] smp_a,
    output logic [OUT_W-1:0] smp_b,
    output logic             smp_valid
);
    halves_t rise_now, fall_prev, even_al, odd_al;
    logic    pair_ok;
    words_t  words;

    adc_ddr_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .ddr_din  (ddr_din),
        .rise_now (rise_now),
        .fall_prev(fall_prev)
    );

    adc_even_realign u_align (
        .clk      (clk),
        .rst      (rst),
        .rise_now (rise_now),
        .fall_prev(fall_prev),
        .even_al  (even_al),
        .odd_al   (odd_al),
        .pair_ok  (pair_ok)
    );

    adc_sample_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .even_al  (even_al),
        .odd_al   (odd_al),
        .pair_ok  (pair_ok),
        .words    (words),
        .words_vld(smp_valid)
    );

    assign smp_a = words[0];
    assign smp_b = words[1];
endmodule

// File: rtl/adc_ddr_assembler_chk.sv
`timescale 1ns/1ps
module adc_ddr_assembler_chk
    import adc_asm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [BUS_W-1:0] ddr_din,
    input logic [OUT_W-1:0] smp_a,
    input logic [OUT_W-1:0] smp_b,
    input logic             smp_valid
);
    logic [BUS_W-1:0] neg_seen;
    logic [1:0]       edges_q;

    always_ff @(negedge clk) begin
        neg_seen <= ddr_din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edges_q <= 2'd0;
        end else if (edges_q != 2'd3) begin
            edges_q <= edges_q + 2'd1;
        end
    end

    // R6
    fill_count_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid == (edges_q == 2'd3));

    // R3
    pair_a_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> smp_a == justify(weave($past(ddr_din[LANE_W-1:0], 3),
                                             $past(neg_seen[LANE_W-1:0], 2))));

    // R8
    pair_b_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> smp_b == justify(weave($past(ddr_din[BUS_W-1:LANE_W], 3),
                                             $past(neg_seen[BUS_W-1:LANE_W], 2))));

    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        smp_a[PAD_W-1:0] == '0 && smp_b[PAD_W-1:0] == '0);

    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!smp_valid && smp_a == '0 && smp_b == '0));
endmodule

bind adc_ddr_assembler adc_ddr_assembler_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ddr_din  (ddr_din),
    .smp_a    (smp_a),
    .smp_b    (smp_b),
    .smp_valid(smp_valid)
);

// File: tb/adc_ddr_assembler_bench.sv
`timescale 1ns/1ps
module adc_ddr_assembler_bench;
    import adc_asm_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [BUS_W-1:0] ddr_din = '0;
    logic [OUT_W-1:0] smp_a, smp_b;
    logic             smp_valid;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          done    = 1'b0;

    logic [2*OUT_W-1:0] sb[$];

    always #2 clk = ~clk;

    adc_ddr_assembler u_adc_ddr_assembler (
        .clk      (clk),
        .rst      (rst),
        .ddr_din  (ddr_din),
        .smp_a    (smp_a),
        .smp_b    (smp_b),
        .smp_valid(smp_valid)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Model of the requirements: rising bit i -> 2+2i, falling bit i -> 3+2i.
    function automatic logic [OUT_W-1:0] model(input logic [LANE_W-1:0] ev, input logic [LANE_W-1:0] od);
        logic [OUT_W-1:0] w;
        w = '0;
        for (int i = 0; i < int'(LANE_W); i++) begin
            w[PAD_W + 2*i]     = ev[i];
            w[PAD_W + 2*i + 1] = od[i];
        end
        return w;
    endfunction

    // Entered and left just after a falling edge.
    task automatic send(input logic [LANE_W-1:0] ea, input logic [LANE_W-1:0] oa,
                        input logic [LANE_W-1:0] eb, input logic [LANE_W-1:0] ob);
        sb.push_back({model(eb, ob), model(ea, oa)});
        ddr_din = {eb, ea};
        @(posedge clk); #1;
        ddr_din = {ob, oa};
        @(negedge clk); #1;
    endtask

    task automatic mid_reset();
        rst = 1'b1;
        sb.delete();
        ddr_din = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
        end
        rst = 1'b0;
    endtask

    // Scoreboard monitor, sampling one time unit after each rising edge.
    initial begin : monitor
        int unsigned n_rel;
        logic [2*OUT_W-1:0] exp;
        n_rel = 0;
        forever begin
            @(posedge clk); #1;
            if (rst) begin
                n_rel = 0;
                check(!smp_valid && smp_a == '0 && smp_b == '0, "R7 reset clears outputs",
                      {smp_valid, smp_b[14:0], smp_a}, 32'h0);
            end else begin
                if (n_rel < 3) n_rel++;
                check(smp_valid == (n_rel >= 3), "R6 valid fill sequence",
                      32'(smp_valid), 32'(n_rel >= 3));
                if (smp_valid) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R5 result with no pending conversion", {smp_b, smp_a}, 32'h0);
                    end else begin
                        exp = sb.pop_front();
                        check(smp_a == exp[OUT_W-1:0], "R1/R2/R3/R5 channel A word",
                              32'(smp_a), 32'(exp[OUT_W-1:0]));
                        check(smp_b == exp[2*OUT_W-1:OUT_W], "R8 channel B word",
                              32'(smp_b), 32'(exp[2*OUT_W-1:OUT_W]));
                        check(smp_a[1:0] == 2'b00 && smp_b[1:0] == 2'b00, "R4 zero padding",
                              {smp_b[1:0], smp_a[1:0]}, 32'h0);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        #800000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R5 watchdog expired, actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
        end
        rst = 1'b0;

        // Flat patterns.
        send(7'h00, 7'h00, 7'h00, 7'h00);
        send(7'h7f, 7'h7f, 7'h7f, 7'h7f);
        // R3: skewed pairing would mix these halves.
        for (int i = 0; i < 6; i++) begin
            send(7'h7f, 7'h00, 7'h00, 7'h7f);
            send(7'h00, 7'h7f, 7'h7f, 7'h00);
        end
        // R1 / R2 / R8: walking ones on each line, other channel quiet.
        for (int i = 0; i < int'(LANE_W); i++) begin
            send(7'(1 << i), 7'h00, 7'h00, 7'h00);
            send(7'h00, 7'(1 << i), 7'h00, 7'h00);
        end
        for (int i = 0; i < int'(LANE_W); i++) begin
            send(7'h00, 7'h00, 7'(1 << i), 7'h00);
            send(7'h00, 7'h00, 7'h00, 7'(1 << i));
        end
        // Mixed data.
        for (int i = 0; i < 150; i++) begin
            send(7'($urandom), 7'($urandom), 7'($urandom), 7'($urandom));
        end

        // R7: reset in the middle of a stream, then refill.
        mid_reset();
        for (int i = 0; i < 30; i++) begin
            send(7'($urandom), 7'($urandom), 7'($urandom), 7'($urandom));
        end

        // Drain: the last conversion appears after two more rising edges.
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); #1;
        end
        check(sb.size() == 0, "R5 every conversion delivered", 32'(sb.size()), 32'h0);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule